// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking in-memory translation tables. Each walk starts at a context table. The base of that table comes from a root pointer input, and a context number input selects one slot in it. From there the walker follows up to three levels of 32-bit descriptors over a plain memory request port. Only one read is outstanding at a time, and read data may come back after any number of cycles.

Each descriptor holds a 2-bit kind in its two lowest bits: 0 is empty, 1 points to the next table, 2 is a leaf mapping and 3 is reserved. A leaf found at level 1, 2 or 3 maps a 16 MB, 256 KB or 4 KB page. When the walk reaches a leaf, the walker presents the leaf to an external permission block and waits for that block's verdict. If the access is allowed, the walker sets the referenced bit, and on a write also the modified bit. It writes the descriptor back to the slot it was read from, but only when one of those bits actually changed. It then reports the physical address, the level and the final descriptor. Any other outcome ends in a fault code that holds the level and the fault kind.

Requests use a valid/ready handshake, and each accepted request produces exactly one result pulse. The result is either a completion or a fault.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk is at address (root << 4) + (context << 2).
- R2: A pointer descriptor at table level L (0 to 2) makes the next read address ({desc[31:2], 6'b0}) plus 4 times the index. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R3: A leaf at level 1 completes with level code 1 and physical address {desc[31:8], 12'b0} + {VA[23:12], 12'b0}.
- R4: A leaf at level 2 completes with level code 2 and physical address {desc[31:8], 12'b0} + {VA[17:12], 12'b0}.
- R5: A leaf at level 3 completes with level code 3 and physical address {desc[31:8], 12'b0}, so the result is always 4 KB aligned.
- R6: An empty descriptor (kind 0) at level L ends the walk with fault code bits [9:8] = L and bits [4:2] = 1. All other code bits are 0.
- R7: The following end the walk with fault kind 4 and the level of the offending descriptor: a reserved descriptor (kind 3) at any level, a pointer at level 3, or a leaf in the context slot (level 0).
- R8: Bit 5 is the referenced bit and bit 6 the modified bit. After an allowed leaf, the walker writes the descriptor back to the address it was read from. The value written has bit 5 set, and bit 6 also set on a write. The write-back happens only if this changes the value. The completion reports the updated descriptor.
- R9: When the permission block denies the leaf, the walk ends with fault bits [9:8] = leaf level and bits [4:2] = the code that block supplies, and no write-back takes place.
- R10: A request is taken only while `req_ready` is high, and `req_ready` stays low until the walk ends. Each accepted request yields exactly one `done` or `flt_valid` pulse. The walker holds its memory request stable until it is accepted and tolerates any read latency.
- R11: After reset, `req_ready` is high and `mem_req_valid`, `done` and `flt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_ptr | input | 32 | Context table base, in units of 16 bytes |
| ctx_num | input | CTX_W | Context number selecting the first slot |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_super | input | 1 | Request is made in supervisor mode |
| chk_valid | output | 1 | A leaf is waiting for a permission verdict |
| chk_entry | output | 32 | Leaf descriptor under check |
| chk_write | output | 1 | Store flag of the walk under check |
| chk_fetch | output | 1 | Fetch flag of the walk under check |
| chk_super | output | 1 | Supervisor flag of the walk under check |
| chk_deny | input | 1 | Permission block refuses the access |
| chk_code | input | 3 | Fault kind supplied with a refusal |
| mem_req_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Byte address of the descriptor |
| mem_wdata | output | 32 | Descriptor value to write |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 36 | Translated physical address |
| done_level | output | 2 | Level of the leaf, which gives the page size |
| done_entry | output | 32 | Final descriptor after bit updates |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_code | output | 10 | Fault level in [9:8], fault kind in [4:2] |

## Verification
A wrong level counter or a wrong index selection shows up on the very next memory request, as a read address off the expected table slot. A wrong kind decode ends the walk one cycle after the read data arrives, with the wrong pulse or the wrong code. A stale update mask or a stale change flag only becomes visible when the walk completes. It appears as a missing, extra or wrongly valued write on the memory port, which is why repeated walks over the same leaf are compared against the sequence of writes they produce.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENT_W = 32;
  localparam int PA_W  = ENT_W + 4;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_PTR     = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } ent_kind_t;

  localparam logic [2:0] FT_EMPTY  = 3'd1;
  localparam logic [2:0] FT_TRANSL = 3'd4;

  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_LEAF    = 2'd1,
    ACT_FAULT   = 2'd2
  } walk_act_t;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_REQ  = 3'd1,
    S_RD_WAIT = 3'd2,
    S_CHECK   = 3'd3,
    S_WB      = 3'd4,
    S_DONE    = 3'd5,
    S_FAULT   = 3'd6
  } walk_st_t;

  // address of the context slot selected by root and context number
  function automatic logic [PA_W-1:0] ctx_slot_addr(input logic [ENT_W-1:0] root,
                                                    input logic [ENT_W-1:0] ctx);
    return {root, 4'b0} + {2'b0, ctx, 2'b0};
  endfunction

  // table index taken from the virtual address for table level lvl
  function automatic logic [7:0] level_index(input logic [ENT_W-1:0] va,
                                             input logic [1:0] lvl);
    case (lvl)
      2'd1:    return va[31:24];
      2'd2:    return {2'b0, va[23:18]};
      2'd3:    return {2'b0, va[17:12]};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] next_table_addr(input logic [ENT_W-1:0] ptr,
                                                      input logic [ENT_W-1:0] va,
                                                      input logic [1:0] lvl);
    return {ptr[ENT_W-1:2], 6'b0} + {26'b0, level_index(va, lvl), 2'b0};
  endfunction

  // part of the virtual address kept above the 4 KB boundary
  function automatic logic [PA_W-1:0] leaf_offset(input logic [ENT_W-1:0] va,
                                                  input logic [1:0] lvl);
    case (lvl)
      2'd1:    return {12'b0, va[23:12], 12'b0};
      2'd2:    return {18'b0, va[17:12], 12'b0};
      default: return '0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] leaf_phys(input logic [ENT_W-1:0] ent,
                                                input logic [ENT_W-1:0] va,
                                                input logic [1:0] lvl);
    return {ent[ENT_W-1:8], 12'b0} + leaf_offset(va, lvl);
  endfunction

  function automatic logic [9:0] fault_word(input logic [1:0] lvl,
                                            input logic [2:0] kind);
    return {lvl, 3'b000, kind, 2'b00};
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             first_i,
  input  logic [ENT_W-1:0] root_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [ENT_W-1:0] ptr_i,
  input  logic [ENT_W-1:0] va_i,
  input  logic [1:0]       lvl_i,
  output logic [PA_W-1:0]  addr_o
);

  logic [ENT_W-1:0] ctx_ext;
  logic [PA_W-1:0]  slot_addr;
  logic [PA_W-1:0]  table_addr;

  assign ctx_ext    = {{(ENT_W-CTX_W){1'b0}}, ctx_i};
  assign slot_addr  = ctx_slot_addr(root_i, ctx_ext);
  assign table_addr = next_table_addr(ptr_i, va_i, lvl_i);
  assign addr_o     = first_i ? slot_addr : table_addr;

endmodule

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic [1:0] lvl_i,
  output walk_act_t  act_o,
  output logic [2:0] fkind_o
);

  always_comb begin
    act_o   = ACT_FAULT;
    fkind_o = FT_TRANSL;
    case (ent_kind_t'(kind_i))
      ET_INVALID: begin
        act_o   = ACT_FAULT;
        fkind_o = FT_EMPTY;
      end
      ET_PTR: begin
        // the last level must hold a leaf
        if (lvl_i != 2'd3) act_o = ACT_DESCEND;
      end
      ET_LEAF: begin
        // a leaf in the context slot is not a valid mapping
        if (lvl_i != 2'd0) act_o = ACT_LEAF;
      end
      default: begin
        act_o   = ACT_FAULT;
        fkind_o = FT_TRANSL;
      end
    endcase
  end

endmodule

// File: rtl/ptw_leaf_upd.sv
module ptw_leaf_upd
  import ptw_pkg::*;
#(
  parameter int REF_BIT = 5,
  parameter int MOD_BIT = 6
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic [ENT_W-1:0] va_i,
  input  logic [1:0]       lvl_i,
  input  logic             write_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic [ENT_W-1:0] entry_o,
  output logic             changed_o
);

  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask          = '0;
    set_mask[REF_BIT] = 1'b1;
    if (write_i) set_mask[MOD_BIT] = 1'b1;
  end

  assign entry_o   = entry_i | set_mask;
  assign changed_o = (entry_o != entry_i);
  assign paddr_o   = leaf_phys(entry_i, va_i, lvl_i);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W   = 8,
  parameter int REF_BIT = 5,
  parameter int MOD_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      root_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             req_super,
  output logic             chk_valid,
  output logic [31:0]      chk_entry,
  output logic             chk_write,
  output logic             chk_fetch,
  output logic             chk_super,
  input  logic             chk_deny,
  input  logic [2:0]       chk_code,
  output logic             mem_req_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [35:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic [35:0]      done_paddr,
  output logic [1:0]       done_level,
  output logic [31:0]      done_entry,
  output logic             flt_valid,
  output logic [9:0]       flt_code
);

  walk_st_t         state_q;
  logic [1:0]       lvl_q;
  logic [ENT_W-1:0] va_q;
  logic             wr_q, fetch_q, sup_q;
  logic [ENT_W-1:0] entry_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic [9:0]       fcode_q;

  // named events for the assertions
  logic accept_ev;
  logic rd_return_ev;
  logic deny_ev;
  logic grant_ev;

  logic [PA_W-1:0]  next_addr;
  walk_act_t        act;
  logic [2:0]       fkind;
  logic [PA_W-1:0]  leaf_pa;
  logic [ENT_W-1:0] leaf_new;
  logic             leaf_changed;

  assign accept_ev    = req_valid && req_ready;
  assign rd_return_ev = (state_q == S_RD_WAIT) && mem_rvalid;
  assign deny_ev      = (state_q == S_CHECK) && chk_deny;
  assign grant_ev     = (state_q == S_CHECK) && !chk_deny;

  ptw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .first_i (state_q == S_IDLE),
    .root_i  (root_ptr),
    .ctx_i   (ctx_num),
    .ptr_i   (mem_rdata),
    .va_i    (va_q),
    .lvl_i   (lvl_q + 2'd1),
    .addr_o  (next_addr)
  );

  ptw_classify u_cls (
    .kind_i  (mem_rdata[1:0]),
    .lvl_i   (lvl_q),
    .act_o   (act),
    .fkind_o (fkind)
  );

  ptw_leaf_upd #(.REF_BIT(REF_BIT), .MOD_BIT(MOD_BIT)) u_leaf (
    .entry_i   (entry_q),
    .va_i      (va_q),
    .lvl_i     (lvl_q),
    .write_i   (wr_q),
    .paddr_o   (leaf_pa),
    .entry_o   (leaf_new),
    .changed_o (leaf_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lvl_q   <= 2'd0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      sup_q   <= 1'b0;
      entry_q <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fcode_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept_ev) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            fetch_q <= req_fetch;
            sup_q   <= req_super;
            lvl_q   <= 2'd0;
            addr_q  <= next_addr;
            state_q <= S_RD_REQ;
          end
        end
        S_RD_REQ: begin
          if (mem_ready) state_q <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (rd_return_ev) begin
            entry_q <= mem_rdata;
            case (act)
              ACT_DESCEND: begin
                lvl_q   <= lvl_q + 2'd1;
                addr_q  <= next_addr;
                state_q <= S_RD_REQ;
              end
              ACT_LEAF: state_q <= S_CHECK;
              default: begin
                fcode_q <= fault_word(lvl_q, fkind);
                state_q <= S_FAULT;
              end
            endcase
          end
        end
        S_CHECK: begin
          if (deny_ev) begin
            fcode_q <= fault_word(lvl_q, chk_code);
            state_q <= S_FAULT;
          end else begin
            paddr_q <= leaf_pa;
            entry_q <= leaf_new;
            state_q <= leaf_changed ? S_WB : S_DONE;
          end
        end
        S_WB: begin
          if (mem_ready) state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        S_FAULT: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WB);
  assign mem_we        = (state_q == S_WB);
  assign mem_addr      = addr_q;
  assign mem_wdata     = entry_q;

  assign chk_valid = (state_q == S_CHECK);
  assign chk_entry = entry_q;
  assign chk_write = wr_q;
  assign chk_fetch = fetch_q;
  assign chk_super = sup_q;

  assign done       = (state_q == S_DONE);
  assign done_paddr = paddr_q;
  assign done_level = lvl_q;
  assign done_entry = entry_q;
  assign flt_valid  = (state_q == S_FAULT);
  assign flt_code   = fcode_q;

  // R10: never both outcomes at once
  a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && flt_valid));

  // R10: no second request while a walk runs
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !req_ready);

  // R10: request held until the memory takes it
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ready) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_we)));

  // R8: every write-back carries the referenced bit
  a_r8_wb_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> mem_wdata[REF_BIT]);

  // R9: a refusal ends in a fault, never a write
  a_r9_deny_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_deny) |=> (flt_valid && !mem_req_valid));

  // R5: completions are page aligned
  a_r5_aligned_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_paddr[11:0] == 12'h000));

endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_ptr = 32'h0001_0000;
  logic [7:0]  ctx_num = 8'd3;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic        req_super = 1'b1;
  logic        chk_valid;
  logic [31:0] chk_entry;
  logic        chk_write, chk_fetch, chk_super;
  logic        tb_deny = 1'b0;
  logic        chk_deny;
  logic [2:0]  chk_code = 3'd0;
  logic        mem_req_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [35:0] done_paddr;
  logic [1:0]  done_level;
  logic [31:0] done_entry;
  logic        flt_valid;
  logic [9:0]  flt_code;

  int n_chk = 0;
  int n_err = 0;

  assign chk_deny = tb_deny && chk_valid;

  always #5ns clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk, .rst_n, .root_ptr, .ctx_num,
    .req_valid, .req_ready, .req_vaddr, .req_write, .req_fetch, .req_super,
    .chk_valid, .chk_entry, .chk_write, .chk_fetch, .chk_super, .chk_deny, .chk_code,
    .mem_req_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata,
    .done, .done_paddr, .done_level, .done_entry, .flt_valid, .flt_code
  );

  // memory model: sparse storage, variable latency, optional ready stalls
  logic [31:0] mem [logic [35:0]];
  logic        poke_en = 1'b0;
  logic [35:0] poke_addr = '0;
  logic [31:0] poke_data = '0;
  int          lat = 1;
  logic        rdy_toggle = 1'b0;
  int          pend = 0;
  logic [35:0] pend_addr = '0;
  logic [35:0] rd_log [16];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [35:0] wr_addr_last = '0;
  logic [31:0] wr_data_last = '0;
  int          res_cnt = 0;

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] = poke_data;
    if (done || flt_valid) res_cnt <= res_cnt + 1;
    mem_ready <= rdy_toggle ? ~mem_ready : 1'b1;
    mem_rvalid <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
      end
    end else if (mem_req_valid && mem_ready && !mem_we) begin
      pend_addr <= mem_addr;
      pend <= lat;
      rd_log[rd_cnt % 16] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_req_valid && mem_ready && mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_cnt <= wr_cnt + 1;
      wr_addr_last <= mem_addr;
      wr_data_last <= mem_wdata;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [35:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_ptr(input logic [35:0] base);
    return base[35:4] | 32'h1;
  endfunction

  function automatic logic [31:0] mk_leaf(input logic [35:0] pa);
    return {pa[35:12], 8'h02};
  endfunction

  // result of the last walk
  logic        got_done;
  logic [35:0] got_pa;
  logic [1:0]  got_lvl;
  logic [31:0] got_ent;
  logic [9:0]  got_fc;
  int          rd_base, wr_base, res_base;

  task automatic walk(input logic [31:0] va, input logic wr, input logic deny, input logic [2:0] dcode);
    bit seen = 0;
    rd_base = rd_cnt; wr_base = wr_cnt; res_base = res_cnt;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    tb_deny = deny; chk_code = dcode;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", {63'b0, req_ready}, 64'd0);
    for (int i = 0; i < 500 && !seen; i++) begin
      if (done || flt_valid) begin
        seen = 1;
        got_done = done; got_pa = done_paddr; got_lvl = done_level;
        got_ent = done_entry; got_fc = flt_code;
      end else @(negedge clk);
    end
    if (!seen) begin
      n_chk++; n_err++;
      $display("FAIL R10 walk timeout: actual none expected result");
    end
    repeat (3) @(negedge clk);
    chk("R10 one result per request", 64'(res_cnt - res_base), 64'd1);
    tb_deny = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 ready", {63'b0, req_ready}, 64'd1);
    chk("R11 mem idle", {63'b0, mem_req_valid}, 64'd0);
    chk("R11 no done", {63'b0, done}, 64'd0);
    chk("R11 no fault", {63'b0, flt_valid}, 64'd0);
  endtask

  task automatic t_level3;
    // first touch, read: reads at ctx slot and three tables, R bit written back
    walk(32'h1234_5678, 1'b0, 1'b0, 3'd0);
    chk("R1 ctx slot addr", 64'(rd_log[rd_base % 16]), 64'(36'h1_0000 * 16 + 3 * 4));
    chk("R2 L1 addr", 64'(rd_log[(rd_base + 1) % 16]), 64'(36'h20_0000 + 36'h12 * 4));
    chk("R2 L2 addr", 64'(rd_log[(rd_base + 2) % 16]), 64'(36'h30_0000 + 36'h0D * 4));
    chk("R2 L3 addr", 64'(rd_log[(rd_base + 3) % 16]), 64'(36'h40_0000 + 36'h05 * 4));
    chk("R5 done", {63'b0, got_done}, 64'd1);
    chk("R5 paddr", 64'(got_pa), 64'h0_ABCD_E000);
    chk("R5 level", 64'(got_lvl), 64'd3);
    chk("R8 one write", 64'(wr_cnt - wr_base), 64'd1);
    chk("R8 write addr", 64'(wr_addr_last), 64'(36'h40_0014));
    chk("R8 write data ref", 64'(wr_data_last), 64'h0ABC_DE22);
    chk("R8 entry out", 64'(got_ent), 64'h0ABC_DE22);
    // second read: nothing changes, so no write
    walk(32'h1234_5000, 1'b0, 1'b0, 3'd0);
    chk("R8 no write when set", 64'(wr_cnt - wr_base), 64'd0);
    chk("R8 entry unchanged", 64'(got_ent), 64'h0ABC_DE22);
    // store sets modified bit
    walk(32'h1234_5abc, 1'b1, 1'b0, 3'd0);
    chk("R8 store one write", 64'(wr_cnt - wr_base), 64'd1);
    chk("R8 store data", 64'(wr_data_last), 64'h0ABC_DE62);
    walk(32'h1234_5abc, 1'b1, 1'b0, 3'd0);
    chk("R8 store no rewrite", 64'(wr_cnt - wr_base), 64'd0);
  endtask

  task automatic t_level1;
    walk(32'h40AB_C123, 1'b0, 1'b0, 3'd0);
    chk("R3 done", {63'b0, got_done}, 64'd1);
    chk("R3 paddr", 64'(got_pa), 64'h7_00AB_C000);
    chk("R3 level", 64'(got_lvl), 64'd1);
    chk("R3 reads", 64'(rd_cnt - rd_base), 64'd2);
    chk("R8 L1 write", 64'(wr_data_last), 64'h7000_0022);
  endtask

  task automatic t_level2;
    walk(32'h1289_5000, 1'b1, 1'b0, 3'd0);
    chk("R4 done", {63'b0, got_done}, 64'd1);
    chk("R4 paddr", 64'(got_pa), 64'h0_8001_5000);
    chk("R4 level", 64'(got_lvl), 64'd2);
    chk("R8 L2 write", 64'(wr_data_last), 64'h0800_0062);
    chk("R8 L2 write addr", 64'(wr_addr_last), 64'(36'h30_0000 + 36'h22 * 4));
  endtask

  task automatic t_faults;
    walk(32'h5000_0000, 1'b0, 1'b0, 3'd0);
    chk("R6 L1 empty", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h104});
    walk(32'h6000_0000, 1'b0, 1'b0, 3'd0);
    chk("R7 L2 reserved", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h210});
    walk(32'h6004_0000, 1'b0, 1'b0, 3'd0);
    chk("R7 L3 pointer", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h310});
    walk(32'h6004_1000, 1'b0, 1'b0, 3'd0);
    chk("R6 L3 empty", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h304});
    chk("R6 no write on fault", 64'(wr_cnt - wr_base), 64'd0);
    ctx_num = 8'd5;
    walk(32'h1234_5000, 1'b0, 1'b0, 3'd0);
    chk("R7 leaf in ctx slot", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h010});
    chk("R1 ctx5 slot addr", 64'(rd_log[rd_base % 16]), 64'(36'h10_0014));
    ctx_num = 8'd6;
    walk(32'h1234_5000, 1'b0, 1'b0, 3'd0);
    chk("R6 ctx empty", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h004});
    ctx_num = 8'd3;
  endtask

  function automatic logic flt_valid_seen();
    return !got_done;
  endfunction

  task automatic t_deny;
    walk(32'h1234_5000, 1'b0, 1'b1, 3'd3);
    chk("R9 deny fault", {54'b0, flt_valid_seen(), got_fc}, {54'b0, 1'b1, 10'h30C});
    chk("R9 no write", 64'(wr_cnt - wr_base), 64'd0);
  endtask

  task automatic t_slow_memory;
    lat = 6;
    rdy_toggle = 1'b1;
    walk(32'h1289_5fff, 1'b0, 1'b0, 3'd0);
    chk("R10 slow paddr", 64'(got_pa), 64'h0_8001_5000);
    chk("R10 slow reads", 64'(rd_cnt - rd_base), 64'd3);
    walk(32'h1234_5000, 1'b0, 1'b0, 3'd0);
    chk("R10 slow L3 paddr", 64'(got_pa), 64'h0_ABCD_E000);
    lat = 1;
    rdy_toggle = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    // context slots
    poke(36'h10_000C, mk_ptr(36'h20_0000));
    poke(36'h10_0014, 32'h0000_0002);
    // L1 table
    poke(36'h20_0000 + 36'h12 * 4, mk_ptr(36'h30_0000));
    poke(36'h20_0000 + 36'h40 * 4, mk_leaf(36'h7_0000_0000));
    poke(36'h20_0000 + 36'h60 * 4, mk_ptr(36'h50_0000));
    // L2 tables
    poke(36'h30_0000 + 36'h0D * 4, mk_ptr(36'h40_0000));
    poke(36'h30_0000 + 36'h22 * 4, mk_leaf(36'h0_8000_0000));
    poke(36'h50_0000, 32'h0000_0003);
    poke(36'h50_0004, mk_ptr(36'h60_0000));
    // L3 tables
    poke(36'h40_0000 + 36'h05 * 4, mk_leaf(36'h0_ABCD_E000));
    poke(36'h60_0000, 32'h0000_0001);
    t_level3;
    t_level1;
    t_level2;
    t_faults;
    t_deny;
    t_slow_memory;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule